// File: doc/BRIEF.md
# Bus-Clocked Wiper Stepper with Tap Decode

This block moves a digital potentiometer's wiper one tap at a time, using the pulses of a two-wire serial bus clock. The command layer raises a stepping-mode enable once it has accepted and acknowledged an increment/decrement command and names the pot to move. From then on, every high pulse of the serial clock is a single step. The level of the serial data line, sampled on the clock's rising edge, sets the direction: high moves the wiper toward the high terminal, and low moves it toward the low terminal. A session may hold any number of steps in either direction, mixed freely, until a stop ends it.

The step is committed when the clock pulse ends, on the falling edge of the serial clock. If the data line changes while the clock is high, or the command layer flags a stop during the pulse, the pulse is a bus condition and not a step, so it is discarded. The wiper saturates at both ends and never wraps.

Each wiper register is decoded into a registered one-hot selection of its tap switches. Code 00h closes the switch at the low end and the all-ones code closes the switch at the high end. The serial clock and data inputs are expected to be synchronized to `clk` already.

Top module: `dcp_wiper_stepper`

## Requirements
- R1: After reset, every wiper output equals RESET_POS (default 8'h80), and each pot's tap vector has exactly bit RESET_POS set.
- R2: With stepping enabled, a serial clock high pulse whose data level is 1 at the rising edge and stays unchanged until the falling edge adds 1 to the selected wiper. The new value appears on the clock cycle after the falling edge is seen.
- R3: The same pulse with the data level held at 0 subtracts 1 from the selected wiper.
- R4: The pot select (0 = first pot in bits [7:0], 1 = second pot in bits [15:8]) is captured at the rising edge. Only that pot moves, and the other wiper keeps its value.
- R5: While the stepping enable is low, clock pulses leave both wipers unchanged.
- R6: A wiper at FFh stays at FFh on an increment pulse and never wraps to 00h.
- R7: A wiper at 00h stays at 00h on a decrement pulse and never wraps to FFh.
- R8: A pulse during which the data line changes level while the clock is high, or during which the stop input is asserted, causes no step.
- R9: For each pot, the tap vector (pot p in bits [p*256 +: 256]) has exactly one bit set, at the index equal to that pot's wiper value. It updates one clock cycle after the wiper changes.
- R10: An arbitrary mix of increment and decrement pulses within one session leaves the wiper at the saturating running sum of the steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level |
| step_en_i | input | 1 | Stepping mode enabled by the command layer |
| pot_sel_i | input | 1 | Pot to step (SEL_W bits) |
| stop_i | input | 1 | Stop condition seen by the command layer |
| wiper_o | output | 16 | Wiper values, pot p in bits [p*8 +: 8] |
| tap_o | output | 512 | One-hot tap enables, pot p in bits [p*256 +: 256] |

## Verification
The first pot is driven from the middle of its range to the top with single increments, then to the bottom with single decrements. After every pulse the bench compares the wiper value and the full one-hot tap vector, so every code and both saturation points are covered. Alternating and irregular up/down mixes on the second pot separate a correct direction latch from one that reads the data line at the wrong edge. Pulses carrying a mid-high data change, a stop flag or a low enable show whether cancellation works, while the untouched pot shows whether the pot select is applied. A sample taken one cycle after a step separates the registered tap decode from a combinational one.

// File: rtl/dcp_step_pkg.sv
package dcp_step_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/dcp_pulse_qualifier.sv
module dcp_pulse_qualifier #(
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             step_en_i,
    input  logic [SEL_W-1:0] pot_sel_i,
    input  logic             stop_i,
    output logic             step_o,
    output dcp_step_pkg::step_dir_e dir_o,
    output logic [SEL_W-1:0] sel_o
);
    import dcp_step_pkg::*;

    typedef struct packed {
        logic             scl;
        logic             armed;
        step_dir_e        dir;
        logic [SEL_W-1:0] sel;
    } qual_t;

    qual_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d   = st_q;
        rise   = scl_i && !st_q.scl;
        fall   = !scl_i && st_q.scl;
        step_o = 1'b0;
        st_d.scl = scl_i;
        if (rise) begin
            st_d.armed = step_en_i && !stop_i;
            st_d.dir   = sda_i ? DIR_UP : DIR_DOWN;
            st_d.sel   = pot_sel_i;
        end else if (scl_i) begin
            if (stop_i || (sda_i != logic'(st_q.dir))) begin
                st_d.armed = 1'b0;
            end
        end else if (fall) begin
            step_o     = st_q.armed && step_en_i && !stop_i;
            st_d.armed = 1'b0;
        end
        dir_o = st_q.dir;
        sel_o = st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, armed: 1'b0, dir: DIR_DOWN, sel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a commit can only happen on a falling serial clock edge
    p_step_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (!scl_i && st_q.scl));
    // R5: with the enable low, no step is issued
    p_no_step_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |-> !step_o);
endmodule

// File: rtl/dcp_wiper_cell.sv
module dcp_wiper_cell #(
    parameter int              WIPER_W   = 8,
    parameter logic [WIPER_W-1:0] RESET_POS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_i,
    input  dcp_step_pkg::step_dir_e dir_i,
    output logic [WIPER_W-1:0] wiper_o
);
    import dcp_step_pkg::*;

    localparam logic [WIPER_W-1:0] TOP = '1;
    localparam logic [WIPER_W-1:0] BOT = '0;

    typedef struct packed {
        logic [WIPER_W-1:0] pos;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i) begin
            if (dir_i == DIR_UP) begin
                if (st_q.pos != TOP) st_d.pos = st_q.pos + 1'b1;
            end else begin
                if (st_q.pos != BOT) st_d.pos = st_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pos: RESET_POS};
        else        st_q <= st_d;
    end

    assign wiper_o = st_q.pos;

    // R6: no wrap from the top code
    p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o == TOP) |=> (wiper_o != BOT));
    // R7: no wrap from the bottom code
    p_no_wrap_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o == BOT) |=> (wiper_o != TOP));
    // R2/R3: a wiper moves by at most one code per cycle
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> ((wiper_o == $past(wiper_o) + 1'b1) ||
                               (wiper_o == $past(wiper_o) - 1'b1)));
    // R4: an unselected pot holds its value
    p_hold_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(wiper_o));
endmodule

// File: rtl/dcp_tap_decoder.sv
module dcp_tap_decoder #(
    parameter int              WIPER_W   = 8,
    parameter logic [WIPER_W-1:0] RESET_POS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIPER_W-1:0] wiper_i,
    output logic [(1<<WIPER_W)-1:0] tap_o
);
    localparam int TAPS = 1 << WIPER_W;

    typedef struct packed {
        logic [TAPS-1:0] tap;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d.tap          = '0;
        st_d.tap[wiper_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tap: TAPS'(1) << RESET_POS};
        else        st_q <= st_d;
    end

    assign tap_o = st_q.tap;

    // R9: exactly one switch closed
    p_one_tap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);
    // R9: the closed switch tracks the wiper one cycle later
    p_tap_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_o[$past(wiper_i)]);
endmodule

// File: rtl/dcp_wiper_stepper.sv
module dcp_wiper_stepper #(
    parameter int NUM_POTS  = 2,
    parameter int WIPER_W   = 8,
    parameter int RESET_POS = 128,
    parameter int SEL_W     = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic                          step_en_i,
    input  logic [SEL_W-1:0]              pot_sel_i,
    input  logic                          stop_i,
    output logic [NUM_POTS*WIPER_W-1:0]   wiper_o,
    output logic [NUM_POTS*(1<<WIPER_W)-1:0] tap_o
);
    import dcp_step_pkg::*;

    localparam int                 TAPS    = 1 << WIPER_W;
    localparam logic [WIPER_W-1:0] RST_VAL = WIPER_W'(RESET_POS);

    logic             step;
    step_dir_e        dir;
    logic [SEL_W-1:0] sel;

    dcp_pulse_qualifier #(.SEL_W(SEL_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .step_en_i (step_en_i),
        .pot_sel_i (pot_sel_i),
        .stop_i    (stop_i),
        .step_o    (step),
        .dir_o     (dir),
        .sel_o     (sel)
    );

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        logic               hit;
        logic [WIPER_W-1:0] pos;

        assign hit = step && (sel == SEL_W'(p));

        dcp_wiper_cell #(.WIPER_W(WIPER_W), .RESET_POS(RST_VAL)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit),
            .dir_i   (dir),
            .wiper_o (pos)
        );

        dcp_tap_decoder #(.WIPER_W(WIPER_W), .RESET_POS(RST_VAL)) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .wiper_i (pos),
            .tap_o   (tap_o[p*TAPS +: TAPS])
        );

        assign wiper_o[p*WIPER_W +: WIPER_W] = pos;
    end
endmodule

// File: tb/dcp_wiper_stepper_tb.sv
module dcp_wiper_stepper_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, en = 1'b0, sel = 1'b0, stp = 1'b0;
    logic [15:0]  wiper;
    logic [511:0] tap;
    int checks = 0, errors = 0;
    int exp_pos [2];
    bit done = 0;

    always #2 clk = ~clk;

    dcp_wiper_stepper u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .step_en_i(en), .pot_sel_i(sel), .stop_i(stp),
        .wiper_o(wiper), .tap_o(tap)
    );

    task automatic check_pot(input int p, input string req);
        logic [7:0]   w;
        logic [255:0] t, e;
        w = wiper[p*8 +: 8];
        t = tap[p*256 +: 256];
        e = 256'd1 << exp_pos[p];
        checks++;
        if (w != 8'(exp_pos[p])) begin
            errors++;
            $display("FAIL %s pot%0d wiper actual %0d expected %0d", req, p, w, exp_pos[p]);
        end
        checks++;
        if (t != e) begin
            errors++;
            $display("FAIL %s pot%0d tap actual ones=%0d expected bit %0d", req, p, $countones(t), exp_pos[p]);
        end
    endtask

    // model: up/down step of pot p if effective
    task automatic pulse(input int p, input bit up, input bit effective);
        @(negedge clk); sel = 1'(p); sda = up;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        scl = 1'b0;
        repeat (3) @(negedge clk);
        if (effective) begin
            if (up) exp_pos[p] = (exp_pos[p] == 255) ? 255 : exp_pos[p] + 1;
            else    exp_pos[p] = (exp_pos[p] == 0)   ? 0   : exp_pos[p] - 1;
        end
    endtask

    initial begin
        exp_pos[0] = 128; exp_pos[1] = 128;
        repeat (3) @(negedge clk);
        check_pot(0, "R1"); check_pot(1, "R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_pot(0, "R1"); check_pot(1, "R1");

        // R5: pulses while disabled
        pulse(0, 1'b1, 1'b0); pulse(1, 1'b0, 1'b0);
        check_pot(0, "R5"); check_pot(1, "R5");
        en = 1'b1;

        // R9: registered decode latency
        @(negedge clk); sel = 1'b0; sda = 1'b1;
        repeat (2) @(negedge clk); scl = 1'b1;
        repeat (3) @(negedge clk); scl = 1'b0;
        @(negedge clk);
        checks++;
        if (wiper[7:0] != 8'd129 || tap[128] != 1'b1 || tap[129] != 1'b0) begin
            errors++;
            $display("FAIL R9 latency wiper actual %0d expected 129, tap128=%b tap129=%b expected 1 0",
                     wiper[7:0], tap[128], tap[129]);
        end
        @(negedge clk);
        checks++;
        if (tap[129] != 1'b1 || tap[128] != 1'b0) begin
            errors++;
            $display("FAIL R9 update tap129=%b tap128=%b expected 1 0", tap[129], tap[128]);
        end
        exp_pos[0] = 129;
        repeat (2) @(negedge clk);

        // R2, R4, R6: sweep pot0 to the top and beyond
        for (int i = 0; i < 130; i++) begin
            pulse(0, 1'b1, 1'b1);
            check_pot(0, (exp_pos[0] == 255) ? "R6" : "R2");
        end
        check_pot(1, "R4");

        // R3, R7: sweep pot0 to the bottom and beyond
        for (int i = 0; i < 258; i++) begin
            pulse(0, 1'b0, 1'b1);
            check_pot(0, (exp_pos[0] == 0) ? "R7" : "R3");
        end
        check_pot(1, "R4");

        // R10: mixed pattern on pot1
        for (int i = 0; i < 40; i++) begin
            pulse(1, ((i % 3) != 1) ^ (i > 25), 1'b1);
            check_pot(1, "R10");
        end
        check_pot(0, "R4");

        // R8: data line change while clock high (stop-like)
        @(negedge clk); sel = 1'b1; sda = 1'b0;
        repeat (2) @(negedge clk); scl = 1'b1;
        repeat (2) @(negedge clk); sda = 1'b1;
        repeat (2) @(negedge clk); scl = 1'b0;
        repeat (3) @(negedge clk);
        check_pot(1, "R8");
        // R8: stop flag during high
        @(negedge clk); sda = 1'b1;
        repeat (2) @(negedge clk); scl = 1'b1;
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
        repeat (2) @(negedge clk); scl = 1'b0;
        repeat (3) @(negedge clk);
        check_pot(1, "R8");
        // normal pulse after cancellation still works
        pulse(1, 1'b1, 1'b1);
        check_pot(1, "R2");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule